// File: doc/BRIEF.md
# Triggered Circular Trace Capture Buffer

This block keeps a running record of trace words in an on-chip circular memory. While capture is enabled, every word presented with its valid strobe is written at the write pointer, which then advances and wraps around the memory. Once the memory has wrapped, the write pointer marks the oldest word still held. A trigger pulse marks the event of interest. From that point the buffer keeps storing a programmed number of further words, then freezes and raises a completion flag. The captured history therefore spans both sides of the event.

Software reaches every register through a simple register bus with a 7-bit address. It programs the post-trigger count, clears and enables an acquisition, and polls status. After completion it sets the read pointer to the oldest word and drains the memory through a data port that advances the read pointer on each read. A formatter-idle input from the upstream trace formatter is shown as a status bit, so software can wait for the pipeline to drain.

Top module: `trace_capture_buf`

## Requirements
- R1: Address 0 returns the ID_VALUE parameter, address 1 returns DEPTH and address 2 returns DATA_W. Writes to these three addresses have no effect.
- R2: The status register at address 3 holds Full in bit 0, Triggered in bit 1, Acquisition-complete in bit 2 and formatter-idle in bit 3, and reads zero above. Bit 3 follows the fmt_idle input in the same cycle.
- R3: While control bit 0 is set and Acquisition-complete is clear, each cycle with trc_valid high stores trc_data at the write pointer (address 6). The pointer then advances by one, modulo DEPTH.
- R4: Full becomes set when a word is stored at location DEPTH-1. It stays set until the next acquisition is armed.
- R5: A trigger pulse sets Triggered only while capture is active. A trigger pulse while Triggered is already set changes nothing and does not restart the post-trigger count.
- R6: With N in the trigger-count register (address 7) when the trigger is taken, exactly N valid words after the trigger cycle are stored. A word in the trigger cycle itself is stored but not counted. In the next active cycle Acquisition-complete sets, and no further word is stored. With N = 0 it sets in the cycle after the trigger.
- R7: The control register at address 8 holds capture enable in bit 0 and demultiplexed-mode select in bit 1, and both read back. Writing it with bit 0 set clears Full, Triggered and Acquisition-complete, and no word is stored in that cycle. Writing bit 0 as zero stops storing.
- R8: A read of address 4 returns the word at the read pointer (address 5), zero-extended to 32 bits. The read pointer then advances by one, modulo DEPTH.
- R9: The read pointer, the write pointer and the 32-bit trigger count can be written and read back. A pointer write keeps the value modulo DEPTH and takes priority over any advance in the same cycle.
- R10: Addresses 9 to 127 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trc_data | input | DATA_W | Trace word |
| trc_valid | input | 1 | Trace word valid strobe |
| trig_in | input | 1 | Trigger event pulse |
| fmt_idle | input | 1 | Upstream formatter holds no pending data |
| reg_addr | input | 7 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (advances read pointer at address 4) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |

## Verification
The bench builds the buffer with DEPTH = 8 and DATA_W = 16. With only eight locations, a burst of trace words wraps the write pointer several times, so Full, the oldest-word position and the read-pointer wrap all occur within a few dozen cycles. A 16-bit word leaves the upper half of the data port empty, so the zero-extension on reads is tested too. Random valid gaps between trigger and completion check that the post-trigger count counts stored words and not cycles.

// File: rtl/tcb_pkg.sv
package tcb_pkg;
  typedef enum logic [6:0] {
    A_IDENT  = 7'd0,
    A_DEPTH  = 7'd1,
    A_WIDTH  = 7'd2,
    A_STATUS = 7'd3,
    A_DATA   = 7'd4,
    A_RPTR   = 7'd5,
    A_WPTR   = 7'd6,
    A_TCOUNT = 7'd7,
    A_CTRL   = 7'd8
  } reg_addr_e;

  typedef struct packed {
    logic fmt_idle;
    logic acq_done;
    logic triggered;
    logic full;
  } status_t;
endpackage

// File: rtl/tcb_ram.sv
module tcb_ram #(
  parameter int DEPTH = 64,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store_q[waddr] <= wdata;
  end

  assign rdata = store_q[raddr];
endmodule

// File: rtl/tcb_acq.sv
module tcb_acq #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic          arm_clr,
  input  logic          wptr_ld,
  input  logic [AW-1:0] wptr_ld_val,
  input  logic [31:0]   trig_cnt,
  input  logic          trc_valid,
  input  logic          trig_in,
  output logic          ram_we,
  output logic [AW-1:0] wptr,
  output logic          full,
  output logic          triggered,
  output logic          acq_done
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] wptr_q, wptr_n;
  logic          full_q, full_n;
  logic          trig_q, trig_n;
  logic          done_q, done_n;
  logic [31:0]   post_q, post_n;
  logic          active, hold, store, take_trig;

  always_comb begin
    active    = cap_en & ~done_q & ~arm_clr;
    hold      = trig_q & (post_q == 32'd0);
    store     = active & trc_valid & ~hold;
    take_trig = active & trig_in & ~trig_q;

    wptr_n = wptr_q;
    if (wptr_ld)    wptr_n = wptr_ld_val;
    else if (store) wptr_n = (wptr_q == LAST) ? '0 : wptr_q + 1'b1;

    post_n = post_q;
    if (take_trig)           post_n = trig_cnt;
    else if (store & trig_q) post_n = post_q - 32'd1;

    if (arm_clr) begin
      full_n = 1'b0;
      trig_n = 1'b0;
      done_n = 1'b0;
    end else begin
      full_n = full_q | (store & (wptr_q == LAST));
      trig_n = trig_q | take_trig;
      done_n = done_q | (active & hold);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      full_q <= 1'b0;
      trig_q <= 1'b0;
      done_q <= 1'b0;
      post_q <= '0;
    end else begin
      wptr_q <= wptr_n;
      full_q <= full_n;
      trig_q <= trig_n;
      done_q <= done_n;
      post_q <= post_n;
    end
  end

  assign ram_we    = store;
  assign wptr      = wptr_q;
  assign full      = full_q;
  assign triggered = trig_q;
  assign acq_done  = done_q;
endmodule

// File: rtl/tcb_regs.sv
module tcb_regs
  import tcb_pkg::*;
#(
  parameter int          DEPTH    = 64,
  parameter int          DATA_W   = 32,
  parameter logic [31:0] ID_VALUE = 32'h7C0B_0001,
  localparam int         AW       = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [6:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [31:0]       reg_wdata,
  input  status_t           status,
  input  logic [AW-1:0]     wptr,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              cap_en,
  output logic [31:0]       trig_cnt,
  output logic [AW-1:0]     rptr,
  output logic              arm_clr,
  output logic              wptr_ld,
  output logic [AW-1:0]     wptr_ld_val
);
  logic [1:0]    ctrl_q, ctrl_n;
  logic [31:0]   tcnt_q, tcnt_n;
  logic [AW-1:0] rptr_q, rptr_n;
  logic          wr_ctrl, wr_tcnt, wr_rptr, rd_data;
  logic [31:0]   rdata_mux;

  always_comb begin
    wr_ctrl = reg_wr & (reg_addr == A_CTRL);
    wr_tcnt = reg_wr & (reg_addr == A_TCOUNT);
    wr_rptr = reg_wr & (reg_addr == A_RPTR);
    rd_data = reg_rd & (reg_addr == A_DATA);

    ctrl_n = wr_ctrl ? reg_wdata[1:0] : ctrl_q;
    tcnt_n = wr_tcnt ? reg_wdata : tcnt_q;
    rptr_n = rptr_q;
    if (wr_rptr)      rptr_n = reg_wdata[AW-1:0];
    else if (rd_data) rptr_n = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      tcnt_q <= '0;
      rptr_q <= '0;
    end else begin
      ctrl_q <= ctrl_n;
      tcnt_q <= tcnt_n;
      rptr_q <= rptr_n;
    end
  end

  always_comb begin
    case (reg_addr)
      A_IDENT:  rdata_mux = ID_VALUE;
      A_DEPTH:  rdata_mux = 32'(DEPTH);
      A_WIDTH:  rdata_mux = 32'(DATA_W);
      A_STATUS: rdata_mux = 32'(status);
      A_DATA:   rdata_mux = 32'(ram_rdata);
      A_RPTR:   rdata_mux = 32'(rptr_q);
      A_WPTR:   rdata_mux = 32'(wptr);
      A_TCOUNT: rdata_mux = tcnt_q;
      A_CTRL:   rdata_mux = 32'(ctrl_q);
      default:  rdata_mux = '0;
    endcase
  end

  assign reg_rdata_int = rdata_mux;
  assign cap_en      = ctrl_q[0];
  assign trig_cnt    = tcnt_q;
  assign rptr        = rptr_q;
  assign arm_clr     = wr_ctrl & reg_wdata[0];
  assign wptr_ld     = reg_wr & (reg_addr == A_WPTR);
  assign wptr_ld_val = reg_wdata[AW-1:0];

  logic [31:0] reg_rdata_int;
endmodule

// File: rtl/trace_capture_buf.sv
module trace_capture_buf
  import tcb_pkg::*;
#(
  parameter int          DEPTH    = 64,
  parameter int          DATA_W   = 32,
  parameter logic [31:0] ID_VALUE = 32'h7C0B_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] trc_data,
  input  logic              trc_valid,
  input  logic              trig_in,
  input  logic              fmt_idle,
  input  logic [6:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);
  localparam int AW = $clog2(DEPTH);

  logic              cap_en, arm_clr, wptr_ld, ram_we;
  logic              full, triggered, acq_done;
  logic [AW-1:0]     wptr, rptr, wptr_ld_val;
  logic [31:0]       trig_cnt;
  logic [DATA_W-1:0] ram_rdata;
  status_t           status;

  assign status = '{fmt_idle: fmt_idle, acq_done: acq_done,
                    triggered: triggered, full: full};

  tcb_acq #(.DEPTH(DEPTH)) u_acq (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .arm_clr(arm_clr),
    .wptr_ld(wptr_ld), .wptr_ld_val(wptr_ld_val), .trig_cnt(trig_cnt),
    .trc_valid(trc_valid), .trig_in(trig_in), .ram_we(ram_we),
    .wptr(wptr), .full(full), .triggered(triggered), .acq_done(acq_done)
  );

  tcb_ram #(.DEPTH(DEPTH), .DW(DATA_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(wptr), .wdata(trc_data),
    .raddr(rptr), .rdata(ram_rdata)
  );

  tcb_regs #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ID_VALUE(ID_VALUE)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .status(status), .wptr(wptr),
    .ram_rdata(ram_rdata), .cap_en(cap_en), .trig_cnt(trig_cnt),
    .rptr(rptr), .arm_clr(arm_clr), .wptr_ld(wptr_ld),
    .wptr_ld_val(wptr_ld_val)
  );

  assign reg_rdata = u_regs.reg_rdata_int;
endmodule

// File: rtl/tcb_checker.sv
module tcb_checker #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cap_en,
  input logic          arm_clr,
  input logic          wptr_ld,
  input logic          full,
  input logic          triggered,
  input logic          acq_done,
  input logic [AW-1:0] wptr,
  input logic [AW-1:0] rptr,
  input logic [6:0]    reg_addr,
  input logic          reg_wr,
  input logic          reg_rd
);
  p_full_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    full && !arm_clr |=> full);

  p_trig_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    triggered && !arm_clr |=> triggered);

  p_done_needs_trig_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acq_done |-> triggered);

  p_frozen_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acq_done && !wptr_ld && !arm_clr |=> $stable(wptr));

  p_idle_no_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en && !wptr_ld |=> $stable(wptr));

  p_arm_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    arm_clr |=> !full && !triggered && !acq_done);

  p_rptr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && reg_addr == 7'd4 && !(reg_wr && reg_addr == 7'd5)
    |=> rptr == AW'(({1'b0, $past(rptr)} + 1) % DEPTH));
endmodule

bind trace_capture_buf tcb_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .arm_clr(arm_clr),
  .wptr_ld(wptr_ld), .full(full), .triggered(triggered),
  .acq_done(acq_done), .wptr(wptr), .rptr(rptr), .reg_addr(reg_addr),
  .reg_wr(reg_wr), .reg_rd(reg_rd)
);

// File: tb/sim_trace_capture_buf.sv
module sim_trace_capture_buf;
  localparam int D = 8;
  localparam int W = 16;
  localparam logic [31:0] IDV = 32'h7C0B_0001;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] trc_data;
  logic         trc_valid, trig_in, fmt_idle;
  logic [6:0]   reg_addr;
  logic         reg_wr, reg_rd;
  logic [31:0]  reg_wdata, reg_rdata;

  always #4 clk = ~clk;

  trace_capture_buf #(.DEPTH(D), .DATA_W(W), .ID_VALUE(IDV)) u0 (
    .clk(clk), .rst_n(rst_n), .trc_data(trc_data), .trc_valid(trc_valid),
    .trig_in(trig_in), .fmt_idle(fmt_idle), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  logic [W-1:0] mm [D];
  int wp, rp, post, tc;
  bit en, dm, fl, tg, aq;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(int a);
    case (a)
      0: return IDV;
      1: return 32'(D);
      2: return 32'(W);
      3: return {28'd0, fmt_idle, aq, tg, fl};
      4: return 32'(mm[rp]);
      5: return 32'(rp);
      6: return 32'(wp);
      7: return 32'(tc);
      8: return {30'd0, dm, en};
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_edge(bit v, logic [W-1:0] d, bit t, bit wr, bit rd,
                            int a, logic [31:0] wd);
    bit arm, active, hold, store, tg0;
    arm    = wr && a == 8 && wd[0];
    active = en && !aq && !arm;
    hold   = tg && post == 0;
    store  = active && v && !hold;
    tg0    = tg;
    if (active && hold) aq = 1;
    if (store) begin
      mm[wp] = d;
      if (wp == D - 1) fl = 1;
      wp = (wp + 1) % D;
      if (tg0) post--;
    end
    if (active && t && !tg0) begin tg = 1; post = tc; end
    if (wr && a == 8) begin
      en = wd[0]; dm = wd[1];
      if (wd[0]) begin fl = 0; tg = 0; aq = 0; end
    end
    if (wr && a == 6) wp = int'(wd % D);
    if (wr && a == 7) tc = int'(wd);
    if (wr && a == 5) rp = int'(wd % D);
    else if (rd && a == 4) rp = (rp + 1) % D;
  endtask

  task automatic drive(bit v, logic [W-1:0] d, bit t, bit wr, bit rd,
                       int a, logic [31:0] wd);
    @(negedge clk);
    trc_valid = v; trc_data = d; trig_in = t;
    reg_wr = wr; reg_rd = rd; reg_addr = 7'(a); reg_wdata = wd;
  endtask

  task automatic tick(bit v, bit t);
    logic [W-1:0] d;
    d = W'($urandom);
    drive(v, d, t, 0, 0, 0, 0);
    @(posedge clk);
    model_edge(v, d, t, 0, 0, 0, 0);
  endtask

  task automatic wreg(int a, logic [31:0] wd);
    drive(0, '0, 0, 1, 0, a, wd);
    @(posedge clk);
    model_edge(0, '0, 0, 1, 0, a, wd);
  endtask

  task automatic rreg(int a, string req);
    drive(0, '0, 0, 0, 1, a, 0);
    #1;
    chk(req, reg_rdata, exp_read(a));
    @(posedge clk);
    model_edge(0, '0, 0, 0, 1, a, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; trc_valid = 0; trc_data = '0; trig_in = 0; fmt_idle = 1;
    reg_addr = '0; reg_wr = 0; reg_rd = 0; reg_wdata = '0;
    wp = 0; rp = 0; post = 0; tc = 0; en = 0; dm = 0; fl = 0; tg = 0; aq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // reset state
    rreg(0, "R1"); rreg(1, "R1"); rreg(2, "R1");
    rreg(3, "R2"); rreg(6, "R9"); rreg(5, "R9"); rreg(7, "R9"); rreg(8, "R7");
    // read-only registers ignore writes
    wreg(1, 32'd99); rreg(1, "R1");
    wreg(0, 32'd5);  rreg(0, "R1");
    wreg(2, 32'd3);  rreg(2, "R1");
    rreg(9, "R10"); rreg(127, "R10");

    // acquisition without wrap, post-trigger count 3
    wreg(7, 3); wreg(6, 0); wreg(8, 1);
    repeat (2) tick(1, 0);
    tick(1, 1);
    for (int i = 0; i < 12; i++) tick(($urandom % 3) != 0, 0);
    rreg(3, "R6"); rreg(6, "R3");
    wreg(5, 0);
    for (int i = 0; i < wp; i++) rreg(4, "R8");

    // wrapped acquisition, second trigger ignored
    wreg(7, 5); wreg(8, 1); rreg(3, "R7");
    for (int i = 0; i < 20; i++) tick(1, 0);
    rreg(3, "R4");
    tick(1, 1);
    tick(1, 0);
    tick(1, 1);
    for (int i = 0; i < 15; i++) tick(($urandom % 2) != 0, 0);
    rreg(3, "R6"); rreg(6, "R5");
    for (int i = 0; i < 4; i++) tick(1, 0);
    rreg(6, "R6");
    wreg(5, wp);
    for (int i = 0; i < D; i++) rreg(4, "R8");

    // zero post-trigger count, demultiplexed bit readback
    wreg(7, 0); wreg(8, 3); rreg(8, "R7");
    tick(1, 0); tick(1, 1); tick(1, 0); tick(1, 0);
    rreg(3, "R6"); rreg(6, "R6");

    // stopping and disabled trigger
    wreg(8, 1); tick(1, 0); wreg(8, 0);
    for (int i = 0; i < 4; i++) tick(1, 0);
    rreg(6, "R7");
    tick(0, 1); rreg(3, "R5");

    // read pointer wrap and pointer writes
    wreg(5, 7); rreg(4, "R8"); rreg(4, "R8"); rreg(5, "R8");
    wreg(6, 13); rreg(6, "R9");
    wreg(5, 32'hFFFF_FFF9); rreg(5, "R9");
    wreg(7, 32'hDEAD_BEEF); rreg(7, "R9");
    fmt_idle = 0; rreg(3, "R2"); fmt_idle = 1; rreg(3, "R2");

    // random traffic
    for (int i = 0; i < 400; i++) begin
      int k;
      k = int'($urandom % 20);
      if (k == 0)      wreg(8, 1);
      else if (k == 1) wreg(7, $urandom % 6);
      else if (k == 2) rreg(3, "R6");
      else if (k == 3) rreg(6, "R3");
      else if (k == 4) rreg(4, "R8");
      else             tick(($urandom % 4) != 0, ($urandom % 10) == 0);
    end
    rreg(3, "R4"); rreg(6, "R3"); rreg(5, "R8");
    finish_run();
  end
endmodule